// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host-side master for a 16-bit sampling converter that sends its result over a serial link. The host supplies the data clock, and that clock does not run between reads. The converter's chip select is assumed tied low, and no frame-sync pulse is used. When the block gets a start request, it drives the read/convert line low for a fixed number of cycles to begin a conversion. It then watches the converter's busy line fall and rise again. Only after that does it send a short burst of data-clock pulses and shift in the result.

The busy line is low while the converter is working. The data clock stays low for that whole time, so switching noise does not disturb the conversion. The converter puts out its MSB after the first rising edge of the data clock, so the first rising-edge sample holds nothing useful. For that reason the burst carries one pulse more than the word width. The sample from the first edge is thrown away, and the next sixteen samples form the word, MSB first. The word appears on a parallel bus for exactly one cycle, together with a valid strobe. If the converter's busy handshake does not finish within a set number of cycles, the block raises a timeout pulse instead.

All inputs are taken to be synchronous to `clk`. The data-clock half period is a parameter, and so are the convert-pulse width and the timeout. With the defaults and a 125 MHz clock, the data clock runs at 12.5 MHz, which is below the converter's 15.15 MHz limit. The convert pulse lasts 64 ns, which is above its 50 ns minimum.

Top module: `adc_read_ctrl`

## Requirements
- R1: After an accepted start, `conv_n_o` goes low for exactly CONV_LOW_CYC consecutive cycles (default 8 cycles, 64 ns at 125 MHz), then returns high.
- R2: `conv_n_o` is high whenever `sclk_o` is high, so read/convert stays high throughout the readout burst.
- R3: `sclk_o` stays low while `busy_i` is low. The first rising edge of `sclk_o` comes SCLK_HALF+1 cycles after `busy_i` returns high.
- R4: Each read produces exactly DATA_W+1 (17) rising edges on `sclk_o`. Each high phase lasts SCLK_HALF cycles, and rising edges are 2*SCLK_HALF cycles apart. `sclk_o` idles low between bursts.
- R5: `sdata_i` is sampled in the cycle that `sclk_o` rises. The sample from the first rising edge is discarded. The samples from rising edges 2 through 17 become `word_o` bits 15 down to 0, MSB first.
- R6: `valid_o` is high for exactly one cycle, SCLK_HALF cycles after the 17th rising edge, and `word_o` holds the assembled word in that cycle.
- R7: `timeout_o` pulses for one cycle, exactly BUSY_TIMEOUT cycles after `conv_n_o` returns high, in two cases: `busy_i` never falls, or it falls and does not rise again. No data-clock pulse and no `valid_o` follow, and the block returns to idle.
- R8: `start_i` is ignored from the cycle a start is accepted until the cycle in which `valid_o` or `timeout_o` is high. A start seen in the cycle after `valid_o` is accepted, so `conv_n_o` falls in the next cycle.
- R9: During and right after reset, `conv_n_o` is high, `sclk_o` is low, and `valid_o`, `timeout_o` and `word_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion and readout |
| busy_i | input | 1 | Converter busy line, low while converting |
| sdata_i | input | 1 | Converter serial data output |
| conv_n_o | output | 1 | Read/convert line, low pulse starts a conversion |
| sclk_o | output | 1 | Data clock to the converter, idles low |
| word_o | output | DATA_W | Assembled conversion result |
| valid_o | output | 1 | One-cycle strobe qualifying `word_o` |
| timeout_o | output | 1 | One-cycle pulse when the busy handshake stalls |

## Verification
Every result of this block is due a fixed number of cycles after a known event. The convert pulse closes 8 cycles after the start is accepted. The first data-clock rise comes SCLK_HALF+1 cycles after busy rises, later rises follow every 2*SCLK_HALF cycles, and the valid strobe comes SCLK_HALF cycles after the 17th rise. A timeout comes BUSY_TIMEOUT cycles after the convert line returns high. A monitor samples at the falling clock edge and stamps each of these events with a cycle number. The directed tasks compare the gaps between stamps against values worked out from the parameters. They also check the captured word against the value the converter model was given, and that model puts a junk bit ahead of the MSB.

// File: rtl/adc_read_ctrl.sv
`timescale 1ns/1ps
module adc_read_ctrl #(
  parameter int DATA_W       = 16,
  parameter int CONV_LOW_CYC = 8,
  parameter int SCLK_HALF    = 5,
  parameter int BUSY_TIMEOUT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              sdata_i,
  output logic              conv_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              timeout_o
);
  localparam int NPULSE = DATA_W + 1;
  localparam int MAXC = (BUSY_TIMEOUT > CONV_LOW_CYC)
                      ? ((BUSY_TIMEOUT > SCLK_HALF) ? BUSY_TIMEOUT : SCLK_HALF)
                      : ((CONV_LOW_CYC > SCLK_HALF) ? CONV_LOW_CYC : SCLK_HALF);
  localparam int CW = $clog2(MAXC + 1);
  localparam int PW = $clog2(NPULSE + 1);

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_WFALL, S_WRISE, S_BURST} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    npls;
  logic [DATA_W-1:0] shreg;

  wire half_done = (cnt == CW'(SCLK_HALF - 1));
  wire conv_done = (cnt == CW'(CONV_LOW_CYC - 1));
  wire wait_exp  = (cnt >= CW'(BUSY_TIMEOUT - 1));
  wire last_pls  = (npls == PW'(NPULSE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      npls      <= '0;
      shreg     <= '0;
      conv_n_o  <= 1'b1;
      sclk_o    <= 1'b0;
      word_o    <= '0;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st       <= S_CONV;
          conv_n_o <= 1'b0;
          cnt      <= '0;
        end
        S_CONV: if (conv_done) begin
          conv_n_o <= 1'b1;
          cnt      <= '0;
          st       <= S_WFALL;
        end else cnt <= cnt + 1'b1;
        S_WFALL: if (!busy_i) begin
          st  <= S_WRISE;
          cnt <= cnt + 1'b1;
        end else if (wait_exp) begin
          timeout_o <= 1'b1;
          st        <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_WRISE: if (busy_i) begin
          st   <= S_BURST;
          cnt  <= '0;
          npls <= '0;
        end else if (wait_exp) begin
          timeout_o <= 1'b1;
          st        <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_BURST: if (half_done) begin
          cnt    <= '0;
          sclk_o <= !sclk_o;
          if (!sclk_o) begin
            npls <= npls + 1'b1;
            if (npls != '0) shreg <= {shreg[DATA_W-2:0], sdata_i};
          end else if (last_pls) begin
            word_o  <= shreg;
            valid_o <= 1'b1;
            st      <= S_IDLE;
          end
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] lowrun;
  logic [PW-1:0] rises;
  logic          sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowrun <= '0;
      rises  <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      lowrun <= conv_n_o ? '0 : lowrun + 1'b1;
      if (!conv_n_o) rises <= '0;
      else if (sclk_o && !sclk_q) rises <= rises + 1'b1;
    end
  end

  a_r1_conv_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n_o) |-> lowrun == CW'(CONV_LOW_CYC));
  a_r2_conv_high_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> conv_n_o);
  a_r3_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> !sclk_o);
  a_r4_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> rises == PW'(NPULSE));
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r7_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!valid_o && conv_n_o && !sclk_o));
endmodule

// File: tb/test_adc_read_ctrl.sv
`timescale 1ns/1ps
module test_adc_read_ctrl;
  localparam int H    = 5;
  localparam int CL   = 8;
  localparam int TO   = 300;
  localparam int CONV = 40;

  logic clk = 0, rst_n = 0, start_i = 0, busy_i = 1, sdata_i = 1;
  logic conv_n_o, sclk_o, valid_o, timeout_o;
  logic [15:0] word_o;

  adc_read_ctrl #(.DATA_W(16), .CONV_LOW_CYC(CL), .SCLK_HALF(H), .BUSY_TIMEOUT(TO)) i_adc_read_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i), .sdata_i(sdata_i),
    .conv_n_o(conv_n_o), .sclk_o(sclk_o), .word_o(word_o), .valid_o(valid_o), .timeout_o(timeout_o));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // converter model: mode 0 normal, 1 busy never falls, 2 busy stuck low
  int mode = 0, dcnt = 0, bitk = 0;
  logic [15:0] dev_val = 0, dev_sr = 0;
  logic rc_d = 1, sc_d = 0;
  always @(posedge clk) begin
    rc_d <= conv_n_o;
    sc_d <= sclk_o;
    if (rc_d && !conv_n_o && mode != 1) dcnt <= 1;
    else if (dcnt > 0) begin
      dcnt <= dcnt + 1;
      if (dcnt == 2) begin busy_i <= 0; sdata_i <= 1; bitk <= 0; end
      if (dcnt == 2 + CONV) begin
        if (mode != 2) begin busy_i <= 1; dev_sr <= dev_val; end
        dcnt <= 0;
      end
    end else if (mode == 0 && !busy_i) busy_i <= 1;
    if (sclk_o && !sc_d) begin
      sdata_i <= (bitk < 16) ? dev_sr[15 - bitk] : 1'b0;
      bitk <= bitk + 1;
    end
  end

  // monitor, sampled at the falling edge
  int cyc = 0, lowrun = 0, low_last = 0, rc_falls = 0, rc_rise_cyc = 0, busy_rise_cyc = 0;
  int viol_busy = 0, viol_rc = 0, hirun = 0, bad_hi = 0, bad_per = 0, rises = 0;
  int first_rise_cyc = 0, last_rise_cyc = 0, valids = 0, valid_cyc = 0, timeouts = 0, to_cyc = 0;
  logic [15:0] valid_word = 0;
  logic rc_p = 1, sclk_p = 0, busy_p = 1;
  bit done = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!conv_n_o) lowrun++;
    else begin if (!rc_p) low_last = lowrun; lowrun = 0; end
    if (!conv_n_o && rc_p) rc_falls++;
    if (conv_n_o && !rc_p) rc_rise_cyc = cyc;
    if (busy_i && !busy_p) busy_rise_cyc = cyc;
    if (!busy_i && sclk_o) viol_busy++;
    if (sclk_o && !conv_n_o) viol_rc++;
    if (sclk_o) hirun++;
    else begin if (sclk_p && hirun != H) bad_hi++; hirun = 0; end
    if (sclk_o && !sclk_p) begin
      if (rises == 0) first_rise_cyc = cyc;
      else if (cyc - last_rise_cyc != 2 * H) bad_per++;
      rises++;
      last_rise_cyc = cyc;
    end
    if (valid_o) begin valids++; valid_cyc = cyc; valid_word = word_o; end
    if (timeout_o) begin timeouts++; to_cyc = cyc; end
    rc_p = conv_n_o; sclk_p = sclk_o; busy_p = busy_i;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clear_mon();
    rc_falls = 0; viol_busy = 0; viol_rc = 0; bad_hi = 0; bad_per = 0;
    rises = 0; valids = 0; timeouts = 0; low_last = 0;
  endtask

  task automatic wait_end(int limit);
    for (int k = 0; k < limit && valids == 0 && timeouts == 0; k++) step();
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) step();
    check(conv_n_o == 1, "R9 conv_n_o in reset", conv_n_o, 1);
    check(sclk_o == 0 && valid_o == 0 && timeout_o == 0, "R9 sclk/valid/timeout in reset",
          {sclk_o, valid_o, timeout_o}, 0);
    rst_n = 1;
    step();
    check(word_o == 0 && conv_n_o == 1, "R9 state after reset", word_o, 0);
  endtask

  task automatic t_read(logic [15:0] val);
    clear_mon();
    mode = 0; dev_val = val;
    start_i = 1; step(); start_i = 0;
    wait_end(3000);
    check(valids == 1, "R6 one valid strobe", valids, 1);
    check(valid_word == val, "R5 captured word", valid_word, val);
    check(low_last == CL, "R1 convert pulse width", low_last, CL);
    check(viol_busy == 0, "R3 no clock while busy low", viol_busy, 0);
    check(first_rise_cyc - busy_rise_cyc == H + 1, "R3 first rise after busy high",
          first_rise_cyc - busy_rise_cyc, H + 1);
    check(viol_rc == 0, "R2 conv_n_o high during burst", viol_rc, 0);
    check(rises == 17, "R4 rising edge count", rises, 17);
    check(bad_hi == 0 && bad_per == 0, "R4 phase timing", bad_hi + bad_per, 0);
    check(valid_cyc - last_rise_cyc == H, "R6 valid after last rise", valid_cyc - last_rise_cyc, H);
    repeat (20) step();
    check(valids == 1 && sclk_o == 0, "R6 single strobe, clock idle", valids, 1);
    check(rc_falls == 1, "R8 one conversion per start", rc_falls, 1);
  endtask

  task automatic t_ignore_start();
    clear_mon();
    mode = 0; dev_val = 16'h3C96;
    start_i = 1; step(); start_i = 0;
    repeat (20) step();
    start_i = 1; step(); start_i = 0;
    for (int k = 0; k < 500 && rises < 5; k++) step();
    start_i = 1; step(); start_i = 0;
    wait_end(3000);
    repeat (30) step();
    check(rc_falls == 1, "R8 starts ignored mid-transaction", rc_falls, 1);
    check(valids == 1 && valid_word == 16'h3C96, "R8 word unaffected", valid_word, 16'h3C96);
  endtask

  task automatic t_back_to_back();
    clear_mon();
    mode = 0; dev_val = 16'h1234;
    start_i = 1;
    wait_end(3000);
    step();
    check(conv_n_o == 0, "R8 start accepted right after valid", conv_n_o, 0);
    start_i = 0;
    check(valid_word == 16'h1234, "R5 first back-to-back word", valid_word, 16'h1234);
    dev_val = 16'hEDCB;
    valids = 0;
    wait_end(3000);
    check(valid_word == 16'hEDCB, "R5 second back-to-back word", valid_word, 16'hEDCB);
  endtask

  task automatic t_timeout(int m, string tag);
    clear_mon();
    mode = m;
    start_i = 1; step(); start_i = 0;
    wait_end(2000);
    check(timeouts == 1, {"R7 timeout pulse ", tag}, timeouts, 1);
    check(to_cyc - rc_rise_cyc == TO, {"R7 timeout delay ", tag}, to_cyc - rc_rise_cyc, TO);
    repeat (5) step();
    check(rises == 0 && valids == 0 && timeouts == 1, {"R7 no clock or valid ", tag},
          rises + valids, 0);
    mode = 0;
    repeat (CONV + 10) step();
  endtask

  initial begin
    t_reset();
    t_read(16'hA5C3);
    t_read(16'h0000);
    t_read(16'hFFFF);
    t_read(16'h8001);
    t_read(16'h7FFE);
    t_ignore_start();
    t_back_to_back();
    t_timeout(1, "busy never falls");
    t_timeout(2, "busy stuck low");
    t_read(16'h5A0F);
    done = 1;
    summary();
  end
endmodule